// File: doc/BRIEF.md
# Multi-Waveform Digital Test Pattern Generator

This block drives the input code of a DAC while a mixed-signal self-test is running. Four small generators feed one output selector: an up/down counter, a maximal-length LFSR, a sweep shift register with its interval divider, and a programmable magnitude register. From these it builds sixteen stimulus waveforms: rising and falling sawtooth, triangle, pseudo-random noise, DC level, impulse, step, and a frequency sweep at fixed or scaled amplitude. Most of them also come in a bit-reversed form. A 4-bit mode code picks the waveform. A small write port loads the mode code and the magnitude.

While `test_en` is low, the block passes `sys_data` through to the DAC with one register of latency. A control state machine has three states: OFF, PRIME and RUN. In OFF the output passes system data through and the generators are held cleared. Raising `test_en` moves OFF to PRIME. PRIME lasts one cycle and drives a quiet baseline. It moves to RUN while `test_en` stays high, and back to OFF when `test_en` is low. In RUN the waveform is emitted. RUN returns to PRIME when a new mode code is written, which restarts the waveform, and returns to OFF when `test_en` falls. A mode write during PRIME keeps the machine in PRIME.

Top module: `wavegen_tpg`

## Requirements
- R1: Reset drives `dac_out` to 0 and clears the mode and magnitude to 0. While `test_en` has been low for the previous two cycles, `dac_out` equals `sys_data` from one clock earlier.
- R2: After `test_en` rises, the second clock edge loads a baseline of 0 into `dac_out`. The level modes (codes 6 and 15) load their level instead. The third edge loads waveform sample 0. A mode write during RUN restarts from the baseline with all generators cleared. A magnitude write does not restart.
- R3: Mode code map: 0 rising ramp, 1 falling ramp, 2 triangle, 3 noise, 4 flat sweep, 5 scaled sweep, 6 level, 7 impulse. Codes 8 to 13 are codes 0 to 5 bit-reversed, 14 is step, and 15 is the level bit-reversed.
- R4: Rising ramp sample k is k mod 2^DW. Falling ramp sample k is (−k) mod 2^DW.
- R5: Triangle sample k counts up from 0 to all-ones and then back down to 0, with period 2·(2^DW−1). No end value repeats.
- R6: Noise is a left-shifting LFSR seeded with 1. Its new LSB is the XOR of the tap bits of a maximal polynomial; for DW=4 this is bit3 XOR bit2. Sample k is the register after k shifts. It is never zero and repeats every 2^DW−1 samples.
- R7: Level mode outputs the magnitude. A magnitude write is seen on the second sample after the write edge.
- R8: Impulse outputs the magnitude on sample 0 only and 0 on every other sample.
- R9: Step outputs 0 at baseline and the magnitude on every sample.
- R10: In the flat sweep, a rising counter holds each value for s+1 samples. The SW-bit register s starts at 1 and rotates left by one each time the counter wraps from all-ones to 0.
- R11: The scaled sweep outputs (counter × magnitude) >> DW, using the same counter timing as R10.
- R12: The reversed modes output the base waveform with bit i moved to bit DW−1−i.
- R13: A write with `wr_sel`=0 loads the mode from `wr_data[3:0]`. A write with `wr_sel`=1 loads the magnitude from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Selects generated stimulus instead of system data |
| sys_data | input | DW | Normal-mode data to the DAC |
| wr_en | input | 1 | Write strobe for the setup registers |
| wr_sel | input | 1 | 0 = mode code, 1 = magnitude |
| wr_data | input | DW | Write data |
| dac_out | output | DW | Registered code to the DAC |

## Verification
A corrupted counter or direction flag shows up at `dac_out` on the next sample as a repeated, skipped or reversed code. A stuck or zeroed LFSR freezes the noise output at once. A sweep register that loses its single set bit changes the hold length of every code at the next counter wrap, so the error can take one full ramp of (s+1)·2^DW samples to appear. A control machine that misses PRIME, or restarts on a magnitude write, moves every later sample by one or more positions, so the baseline and sample-0 checks catch it two edges after the trigger.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } tpg_state_e;

    typedef enum logic [3:0] {
        SRC_UP         = 4'd0,
        SRC_DOWN       = 4'd1,
        SRC_TRI        = 4'd2,
        SRC_NOISE      = 4'd3,
        SRC_SWP_FLAT   = 4'd4,
        SRC_SWP_SCALED = 4'd5,
        SRC_LEVEL      = 4'd6,
        SRC_PULSE      = 4'd7,
        SRC_STEP       = 4'd8
    } tpg_src_e;

    typedef enum logic [1:0] {
        CK_UP   = 2'd0,
        CK_DOWN = 2'd1,
        CK_TRI  = 2'd2
    } cnt_kind_e;

    localparam logic [3:0] CODE_STEP      = 4'd14;
    localparam logic [3:0] CODE_LEVEL_REV = 4'd15;

    // Waveform source selected by a mode code
    function automatic tpg_src_e src_of(input logic [3:0] code);
        if (code == CODE_STEP)      return SRC_STEP;
        if (code == CODE_LEVEL_REV) return SRC_LEVEL;
        return tpg_src_e'({1'b0, code[2:0]});
    endfunction

    // Upper half of the code space applies bit reversal, except the step code
    function automatic logic rev_of(input logic [3:0] code);
        return code[3] && (code != CODE_STEP);
    endfunction

    // Feedback tap mask (bit t-1 set for tap t) of a maximal polynomial
    function automatic logic [23:0] lfsr_taps(input int w);
        case (w)
            4:       return 24'h00000C;
            5:       return 24'h000014;
            6:       return 24'h000030;
            7:       return 24'h000060;
            8:       return 24'h0000B8;
            9:       return 24'h000110;
            10:      return 24'h000240;
            11:      return 24'h000500;
            12:      return 24'h000829;
            13:      return 24'h00100D;
            14:      return 24'h002015;
            15:      return 24'h006000;
            16:      return 24'h00D008;
            17:      return 24'h012000;
            18:      return 24'h020400;
            19:      return 24'h040023;
            20:      return 24'h090000;
            21:      return 24'h140000;
            22:      return 24'h300000;
            23:      return 24'h420000;
            24:      return 24'hE10000;
            default: return 24'h00000C;
        endcase
    endfunction

endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_en,
    input  logic       mode_wr,
    output tpg_state_e state,
    output logic       gen_clr,
    output logic       gen_run,
    output logic       first_q
);

    tpg_state_e state_q;
    tpg_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= (state_q == ST_PRIME);
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (test_en) state_d = ST_PRIME;
            end
            ST_PRIME: begin
                if (!test_en)     state_d = ST_OFF;
                else if (mode_wr) state_d = ST_PRIME;
                else              state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!test_en)     state_d = ST_OFF;
                else if (mode_wr) state_d = ST_PRIME;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        state   = state_q;
        gen_run = (state_q == ST_RUN);
        gen_clr = (state_q != ST_RUN);
    end

endmodule

// File: rtl/tpg_counter.sv
module tpg_counter
    import tpg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  cnt_kind_e     kind,
    output logic [DW-1:0] cnt,
    output logic          wrap
);

    localparam logic [DW-1:0] TOP = {DW{1'b1}};
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic going_down;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            going_down <= 1'b0;
        end else if (clr) begin
            cnt        <= '0;
            going_down <= 1'b0;
        end else if (step) begin
            unique case (kind)
                CK_UP:   cnt <= cnt + ONE;
                CK_DOWN: cnt <= cnt - ONE;
                CK_TRI: begin
                    if (!going_down) begin
                        if (cnt == TOP) begin
                            going_down <= 1'b1;
                            cnt        <= TOP - ONE;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end else begin
                        if (cnt == '0) begin
                            going_down <= 1'b0;
                            cnt        <= ONE;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
                default: cnt <= cnt;
            endcase
        end
    end

    assign wrap = step && (kind == CK_UP) && (cnt == TOP);

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
    import tpg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [DW-1:0] word
);

    localparam logic [DW-1:0] TAPS = DW'(lfsr_taps(DW));
    localparam logic [DW-1:0] SEED = {{(DW-1){1'b0}}, 1'b1};

    logic fb;
    assign fb = ^(word & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= SEED;
        end else if (clr) begin
            word <= SEED;
        end else if (adv) begin
            word <= {word[DW-2:0], fb};
        end
    end

endmodule

// File: rtl/tpg_sweep.sv
module tpg_sweep #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          wrap,
    output logic          tick,
    output logic [SW-1:0] sreg
);

    localparam logic [SW-1:0] START = {{(SW-1){1'b0}}, 1'b1};

    logic [SW-1:0] div;
    logic [SW-1:0] sreg_rot;

    generate
        if (SW == 1) begin : g_single
            assign sreg_rot = sreg;
        end else begin : g_rotate
            assign sreg_rot = {sreg[SW-2:0], sreg[SW-1]};
        end
    endgenerate

    assign tick = en && (div == sreg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div  <= '0;
            sreg <= START;
        end else if (clr) begin
            div  <= '0;
            sreg <= START;
        end else begin
            if (en) begin
                if (tick) div <= '0;
                else      div <= div + 1'b1;
            end
            if (wrap) sreg <= sreg_rot;
        end
    end

endmodule

// File: rtl/wavegen_tpg.sv
module wavegen_tpg
    import tpg_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic [DW-1:0] sys_data,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] dac_out
);

    localparam int CW = 4;

    logic [CW-1:0] mode_q;
    logic [DW-1:0] mag_q;
    logic          mode_wr;

    tpg_state_e    ctrl_state;
    logic          gen_clr;
    logic          gen_run;
    logic          first_q;

    tpg_src_e      src_sel;
    logic          rev_sel;
    cnt_kind_e     kind_sel;
    logic          sweep_mode;

    logic [DW-1:0] cnt_word;
    logic          cnt_wrap;
    logic          cnt_step;
    logic [DW-1:0] lfsr_word;
    logic          sweep_tick;
    logic [SW-1:0] sweep_reg;

    logic [DW-1:0] scaled;
    logic [DW-1:0] raw_wave;
    logic [DW-1:0] rev_wave;
    logic [DW-1:0] shaped;

    assign mode_wr = wr_en && !wr_sel;

    // Setup registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            mag_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) mag_q  <= wr_data;
            else        mode_q <= wr_data[CW-1:0];
        end
    end

    // Mode decode
    always_comb begin
        src_sel    = src_of(mode_q);
        rev_sel    = rev_of(mode_q);
        sweep_mode = (src_sel == SRC_SWP_FLAT) || (src_sel == SRC_SWP_SCALED);
        unique case (src_sel)
            SRC_DOWN: kind_sel = CK_DOWN;
            SRC_TRI:  kind_sel = CK_TRI;
            default:  kind_sel = CK_UP;
        endcase
    end

    tpg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .mode_wr (mode_wr),
        .state   (ctrl_state),
        .gen_clr (gen_clr),
        .gen_run (gen_run),
        .first_q (first_q)
    );

    assign cnt_step = sweep_mode ? sweep_tick : gen_run;

    tpg_counter #(.DW(DW)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gen_clr),
        .step  (cnt_step),
        .kind  (kind_sel),
        .cnt   (cnt_word),
        .wrap  (cnt_wrap)
    );

    tpg_lfsr #(.DW(DW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gen_clr),
        .adv   (gen_run),
        .word  (lfsr_word)
    );

    tpg_sweep #(.SW(SW)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gen_clr),
        .en    (gen_run && sweep_mode),
        .wrap  (cnt_wrap && sweep_mode),
        .tick  (sweep_tick),
        .sreg  (sweep_reg)
    );

    assign scaled = DW'(({{DW{1'b0}}, cnt_word} * {{DW{1'b0}}, mag_q}) >> DW);

    // Source selection
    always_comb begin
        unique case (src_sel)
            SRC_UP, SRC_DOWN, SRC_TRI, SRC_SWP_FLAT: raw_wave = cnt_word;
            SRC_NOISE:      raw_wave = lfsr_word;
            SRC_SWP_SCALED: raw_wave = scaled;
            SRC_LEVEL:      raw_wave = mag_q;
            SRC_STEP:       raw_wave = mag_q;
            SRC_PULSE:      raw_wave = first_q ? mag_q : '0;
            default:        raw_wave = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < DW; i++) begin : g_rev
            assign rev_wave[i] = raw_wave[DW-1-i];
        end
    endgenerate

    assign shaped = rev_sel ? rev_wave : raw_wave;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_out <= '0;
        end else begin
            unique case (ctrl_state)
                ST_OFF:   dac_out <= sys_data;
                ST_PRIME: dac_out <= (src_sel == SRC_LEVEL) ? shaped : '0;
                ST_RUN:   dac_out <= shaped;
                default:  dac_out <= '0;
            endcase
        end
    end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
    import tpg_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          test_en,
    input logic [DW-1:0] sys_data,
    input logic [DW-1:0] dac_out,
    input tpg_state_e    state,
    input tpg_src_e      src,
    input cnt_kind_e     kind,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] lfsr_q,
    input logic [SW-1:0] sreg,
    input logic [DW-1:0] mag_q
);

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(test_en) && !$past(test_en, 2))
        |-> (dac_out == $past(sys_data)));

    p_restart_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> (cnt == '0));

    p_tri_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && kind == CK_TRI) |=> (cnt != $past(cnt)));

    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    p_step_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && src == SRC_STEP) |=> (dac_out == $past(mag_q)));

    p_sweep_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sreg) == 1);

endmodule

bind wavegen_tpg tpg_checker #(.DW(DW), .SW(SW)) u_tpg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .sys_data (sys_data),
    .dac_out  (dac_out),
    .state    (ctrl_state),
    .src      (src_sel),
    .kind     (kind_sel),
    .cnt      (cnt_word),
    .lfsr_q   (lfsr_word),
    .sreg     (sweep_reg),
    .mag_q    (mag_q)
);

// File: tb/wavegen_tpg_test.sv
module wavegen_tpg_test;

    localparam int BDW = 4;
    localparam int BSW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_en = 1'b0;
    logic [BDW-1:0] sys_data = '0;
    logic           wr_en = 1'b0;
    logic           wr_sel = 1'b0;
    logic [BDW-1:0] wr_data = '0;
    logic [BDW-1:0] dac_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [BDW-1:0] lf_model [0:14];
    int             swp_model [0:199];

    always #2.5 clk = ~clk;

    wavegen_tpg #(.DW(BDW), .SW(BSW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .sys_data (sys_data),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .dac_out  (dac_out)
    );

    task automatic chk(input string req, input logic [BDW-1:0] act, input logic [BDW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [BDW-1:0] bitrev(input logic [BDW-1:0] x);
        logic [BDW-1:0] r;
        for (int i = 0; i < BDW; i++) r[i] = x[BDW-1-i];
        return r;
    endfunction

    // Expected sample k of mode m (R3 code map)
    function automatic logic [BDW-1:0] expect_val(input int m, input int k, input logic [BDW-1:0] mag);
        int src;
        int t;
        logic [BDW-1:0] v;
        src = (m == 14) ? 8 : (m == 15) ? 6 : (m % 8);
        case (src)
            0: v = BDW'(k % 16);
            1: v = BDW'((16 - (k % 16)) % 16);
            2: begin t = k % 30; v = BDW'((t <= 15) ? t : 30 - t); end
            3: v = lf_model[k % 15];
            4: v = BDW'(swp_model[k]);
            5: v = BDW'((swp_model[k] * int'(mag)) >> BDW);
            6: v = mag;
            7: v = (k == 0) ? mag : '0;
            default: v = mag;
        endcase
        if (m >= 8 && m != 14) v = bitrev(v);
        return v;
    endfunction

    function automatic string tag_of(input int m);
        string base;
        case ((m == 14) ? 8 : (m == 15) ? 6 : (m % 8))
            0, 1: base = "R4";
            2:    base = "R5";
            3:    base = "R6";
            4:    base = "R10";
            5:    base = "R11";
            6:    base = "R7";
            7:    base = "R8";
            default: base = "R9";
        endcase
        if (m >= 8 && m != 14) return {"R3 R12 ", base};
        return {"R3 ", base};
    endfunction

    // Called and returns at a falling edge
    task automatic write_reg(input logic sel, input logic [BDW-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_test(input logic [BDW-1:0] baseline, input string req);
        test_en = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(req, dac_out, baseline);
    endtask

    task automatic run_mode(input int m, input int n, input logic [BDW-1:0] mag);
        logic [BDW-1:0] base;
        write_reg(1'b0, BDW'(m));   // R13 mode load
        base = (m == 6) ? mag : (m == 15) ? bitrev(mag) : '0;
        start_test(base, "R2 baseline");
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            chk(tag_of(m), dac_out, expect_val(m, k, mag));
        end
        test_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Arithmetic models from R6 and R10
        begin
            logic [BDW-1:0] q;
            q = 4'd1;
            for (int i = 0; i < 15; i++) begin
                lf_model[i] = q;
                q = {q[2:0], q[3] ^ q[2]};
            end
        end
        begin
            int s; int d; int c;
            s = 1; d = 0; c = 0;
            for (int i = 0; i < 200; i++) begin
                swp_model[i] = c;
                if (d == s) begin
                    d = 0;
                    if (c == 15) begin
                        c = 0;
                        s = ((s << 1) | (s >> (BSW - 1))) & ((1 << BSW) - 1);
                    end else c = c + 1;
                end else d = d + 1;
            end
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", dac_out, '0);
        rst_n = 1'b1;

        // R1 pass-through of every code
        for (int v = 0; v < 16; v++) begin
            sys_data = BDW'(v);
            @(negedge clk);
            chk("R1 passthru", dac_out, BDW'(v));
        end

        // R1 reset mode is code 0 (rising ramp)
        start_test('0, "R2 baseline");
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R1 R13 reset mode", dac_out, BDW'(k));
        end
        test_en = 1'b0;
        repeat (3) @(negedge clk);

        // R2 restart on a mode write while running
        write_reg(1'b0, 4'd0);
        start_test('0, "R2 baseline");
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R2 pre-restart", dac_out, BDW'(k));
        end
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'd0;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R2 write edge sample", dac_out, 4'd5);
        @(posedge clk); @(negedge clk);
        chk("R2 restart baseline", dac_out, 4'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 restart sample0", dac_out, 4'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 restart sample1", dac_out, 4'd1);
        sys_data = 4'd9;
        test_en = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1 leave test", dac_out, 4'd9);
        @(negedge clk);

        // R2 R8 magnitude write does not restart the impulse
        write_reg(1'b1, 4'd11);
        write_reg(1'b0, 4'd7);
        start_test('0, "R2 baseline");
        @(posedge clk); @(negedge clk);
        chk("R8 impulse", dac_out, 4'd11);
        @(posedge clk); @(negedge clk);
        chk("R8 impulse tail", dac_out, 4'd0);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'd5;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R2 mag write no restart", dac_out, 4'd0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R2 mag write no restart", dac_out, 4'd0);
        end
        test_en = 1'b0;
        repeat (3) @(negedge clk);

        // R7 level follows a live magnitude write on the second sample
        write_reg(1'b1, 4'd11);
        write_reg(1'b0, 4'd6);
        start_test(4'd11, "R2 R7 level baseline");
        @(posedge clk); @(negedge clk);
        chk("R7 level", dac_out, 4'd11);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'd3;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R7 old level at write", dac_out, 4'd11);
        @(posedge clk); @(negedge clk);
        chk("R7 new level", dac_out, 4'd3);
        test_en = 1'b0;
        repeat (3) @(negedge clk);

        // All sixteen mode codes with magnitude 11 (R13 magnitude load)
        write_reg(1'b1, 4'd11);
        for (int m = 0; m < 16; m++) begin
            int n;
            n = (m == 4 || m == 5 || m == 12 || m == 13) ? 170 : 40;
            run_mode(m, n, 4'd11);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule